// File: doc/BRIEF.md
# Interrupt Acknowledge Capture Unit

This block takes the processor's place on a test fixture when an interrupt arrives. It watches a request line. On a rising edge, if capture is allowed, it runs a two-cycle acknowledge handshake toward an interrupt controller. It does not branch to a service routine. Instead it latches the vector type byte and the cascade address that the controller returns in the second cycle, and raises a "vector available" flag.

While that flag is high, automatic capture is locked out. A host reaches the block through a small register interface. Through it the host can:
- read the captured vector through a port that clears the flag and re-arms capture;
- read the same vector through a second port that leaves the flag alone;
- read the cascade address;
- inspect and change the capture enable;
- force an acknowledge sequence on demand.

A sync output spans the whole acknowledge window. A one-cycle probe pulse marks its end.

Each acknowledge cycle holds `ack_o` high for `ACK_LEN` clocks. The two cycles are separated by `GAP_LEN` low clocks.

Top module: `iack_capture_unit`

## Requirements
- R1: After reset `ack_o`, `sync_o` and `probe_o` are low, the vector-available flag is 0 and the capture enable is 1, so a status read (address 3) returns 8'h02.
- R2: A rising edge on `irq_i`, seen while the enable is 1 and the flag is 0, starts a sequence. The sequence is two `ack_o` pulses of `ACK_LEN` clocks each, separated by `GAP_LEN` low clocks. A request held high does not start another sequence.
- R3: The vector and cascade inputs are sampled only in the last clock of the second acknowledge pulse. Values present during the first pulse or the gap have no effect.
- R4: When a sequence completes, the flag becomes 1. Status address 3 returns the flag in bit 0 and the enable in bit 1, with all other bits zero.
- R5: A rising edge of `irq_i` while the flag is 1 produces no acknowledge. It is not remembered: clearing the flag while the request stays high starts nothing.
- R6: A read of address 0 returns the captured vector and clears the flag, unless a capture completes in that same clock.
- R7: A read of address 1 returns the captured vector and leaves the flag unchanged.
- R8: A read of address 2 returns the cascade address in bits 2:0, with the upper bits zero.
- R9: A write to address 3 loads the enable from `host_wdata_i`. While the enable is 0, request edges produce no acknowledge.
- R10: A write to address 0 starts a full sequence whatever the enable and flag values are. A new capture then overwrites the stored values. A write to address 0 during a running sequence is ignored.
- R11: `sync_o` is high from the first clock of the first pulse through the last clock of the second pulse, which is 2*ACK_LEN+GAP_LEN clocks. `probe_o` is high for exactly the one clock after `sync_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Interrupt request; rising edge triggers capture |
| ack_o | output | 1 | Acknowledge strobe toward the interrupt controller |
| ctl_vec_i | input | VEC_W | Vector type returned by the controller |
| ctl_cas_i | input | CAS_W | Cascade address returned by the controller |
| sync_o | output | 1 | High across the whole acknowledge window |
| probe_o | output | 1 | One-clock pulse after the window ends |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 1 | Enable value for a write to address 3 |
| host_rdata_o | output | VEC_W | Read data, valid in the cycle of the strobe |

## Verification
A sequencer stuck or mis-counting shows up within one sequence as an `ack_o` pulse or gap of the wrong length, or as a `sync_o` window of the wrong span. The monitor measures each of these at the ports.

A wrong sampling point returns the decoy values the responder drives outside the second pulse. This shows up on the very next vector or cascade read.

A flag or enable that is wrong in state shows up as a missing or unexpected acknowledge within a few clocks of a request edge. It is also visible at once in the status read.

// File: rtl/iack_pkg.sv
package iack_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACK1 = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_ACK2 = 2'd3
    } seq_state_e;

    localparam logic [1:0] ADDR_VEC_CLR  = 2'd0;
    localparam logic [1:0] ADDR_VEC_PEEK = 2'd1;
    localparam logic [1:0] ADDR_CAS      = 2'd2;
    localparam logic [1:0] ADDR_CTRL     = 2'd3;

    localparam int STS_AVAIL_BIT = 0;
    localparam int STS_EN_BIT    = 1;
endpackage

// File: rtl/iack_seq.sv
module iack_seq
    import iack_pkg::*;
#(
    parameter int ACK_LEN = 2,
    parameter int GAP_LEN = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic ack_o,
    output logic busy_o,
    output logic sample_o,
    output logic probe_o
);
    localparam int MAXLEN = (ACK_LEN > GAP_LEN) ? ACK_LEN : GAP_LEN;
    localparam int CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
    localparam logic [CW-1:0] ACK_LAST = CW'(ACK_LEN - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_LEN - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [CW-1:0]   cnt;
        logic            probe;
    } seq_t;

    seq_t s_q, s_d;
    logic ack_done;
    logic gap_done;

    always_comb begin
        s_d       = s_q;
        s_d.probe = 1'b0;
        ack_done  = (s_q.cnt == ACK_LAST);
        gap_done  = (s_q.cnt == GAP_LAST);
        sample_o  = 1'b0;
        case (s_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    s_d.state = SEQ_ACK1;
                    s_d.cnt   = '0;
                end
            end
            SEQ_ACK1: begin
                if (ack_done) begin
                    s_d.state = SEQ_GAP;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_GAP: begin
                if (gap_done) begin
                    s_d.state = SEQ_ACK2;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_ACK2: begin
                if (ack_done) begin
                    sample_o  = 1'b1;
                    s_d.state = SEQ_IDLE;
                    s_d.cnt   = '0;
                    s_d.probe = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.state <= SEQ_IDLE;
            s_q.cnt   <= '0;
            s_q.probe <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_o   = (s_q.state == SEQ_ACK1) || (s_q.state == SEQ_ACK2);
    assign busy_o  = (s_q.state != SEQ_IDLE);
    assign probe_o = s_q.probe;

    // R11: probe lasts a single clock
    p_probe_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        probe_o |=> !probe_o);
    // R11: end of the window is always marked by the probe pulse
    p_sync_end_probe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> probe_o);
    // R2: acknowledge is only driven inside the window
    p_ack_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_o) && !$past(busy_o) |-> $past(start_i));
endmodule

// File: rtl/iack_trigger.sv
module iack_trigger (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic irq_i,
    input  logic enable_i,
    input  logic avail_i,
    input  logic force_i,
    input  logic busy_i,
    output logic start_o
);
    typedef struct packed {
        logic irq;
    } trig_t;

    trig_t t_q, t_d;
    logic  irq_rise;

    always_comb begin
        t_d.irq  = irq_i;
        irq_rise = irq_i && !t_q.irq;
        start_o  = !busy_i && (force_i || (irq_rise && enable_i && !avail_i));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q.irq <= 1'b0;
        else         t_q     <= t_d;
    end

    // R5: a request edge never starts a sequence while a vector is held
    p_locked_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && !force_i) |-> (!avail_i && enable_i));
endmodule

// File: rtl/iack_regs.sv
module iack_regs
    import iack_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CAS_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sample_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [CAS_W-1:0] cas_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic             wdata_i,
    output logic [VEC_W-1:0] rdata_o,
    output logic             avail_o,
    output logic             enable_o,
    output logic             force_o
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [CAS_W-1:0] cas;
        logic             avail;
        logic             enable;
    } store_t;

    store_t r_q, r_d;
    logic   rd_clr;

    always_comb begin
        r_d     = r_q;
        rd_clr  = rd_i && (addr_i == ADDR_VEC_CLR);
        force_o = wr_i && (addr_i == ADDR_VEC_CLR);
        if (wr_i && (addr_i == ADDR_CTRL)) r_d.enable = wdata_i;
        if (sample_i) begin
            r_d.vec   = vec_i;
            r_d.cas   = cas_i;
            r_d.avail = 1'b1;
        end else if (rd_clr) begin
            r_d.avail = 1'b0;
        end

        rdata_o = '0;
        case (addr_i)
            ADDR_VEC_CLR, ADDR_VEC_PEEK: rdata_o = r_q.vec;
            ADDR_CAS:  rdata_o[CAS_W-1:0] = r_q.cas;
            default: begin
                rdata_o[STS_AVAIL_BIT] = r_q.avail;
                rdata_o[STS_EN_BIT]    = r_q.enable;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.vec    <= '0;
            r_q.cas    <= '0;
            r_q.avail  <= 1'b0;
            r_q.enable <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign avail_o  = r_q.avail;
    assign enable_o = r_q.enable;

    // R4: the flag only rises from a completed capture
    p_avail_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(avail_o) |-> $past(sample_i));
    // R6: clearing read drops the flag
    p_clear_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADDR_VEC_CLR && !sample_i) |=> !avail_o);
    // R7: peek read keeps the flag
    p_peek_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADDR_VEC_PEEK && !sample_i) |=> $stable(avail_o));
endmodule

// File: rtl/iack_capture_unit.sv
module iack_capture_unit
    import iack_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int CAS_W   = 3,
    parameter int ACK_LEN = 2,
    parameter int GAP_LEN = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             irq_i,
    output logic             ack_o,
    input  logic [VEC_W-1:0] ctl_vec_i,
    input  logic [CAS_W-1:0] ctl_cas_i,
    output logic             sync_o,
    output logic             probe_o,
    input  logic             host_rd_i,
    input  logic             host_wr_i,
    input  logic [1:0]       host_addr_i,
    input  logic             host_wdata_i,
    output logic [VEC_W-1:0] host_rdata_o
);
    logic start, busy, sample, avail, enable, force_req;

    iack_trigger u_trig (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .irq_i    (irq_i),
        .enable_i (enable),
        .avail_i  (avail),
        .force_i  (force_req),
        .busy_i   (busy),
        .start_o  (start)
    );

    iack_seq #(.ACK_LEN(ACK_LEN), .GAP_LEN(GAP_LEN)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .ack_o    (ack_o),
        .busy_o   (busy),
        .sample_o (sample),
        .probe_o  (probe_o)
    );

    iack_regs #(.VEC_W(VEC_W), .CAS_W(CAS_W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (sample),
        .vec_i    (ctl_vec_i),
        .cas_i    (ctl_cas_i),
        .rd_i     (host_rd_i),
        .wr_i     (host_wr_i),
        .addr_i   (host_addr_i),
        .wdata_i  (host_wdata_i),
        .rdata_o  (host_rdata_o),
        .avail_o  (avail),
        .enable_o (enable),
        .force_o  (force_req)
    );

    assign sync_o = busy;

    // R10: a forced sequence starts on the next clock when idle
    p_force_starts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_wr_i && host_addr_i == ADDR_VEC_CLR && !sync_o) |=> $rose(sync_o));
    // R9: with capture disabled, only a force can open a window
    p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sync_o) && !$past(enable)) |-> $past(host_wr_i && host_addr_i == ADDR_VEC_CLR));
endmodule

// File: tb/tb_iack_capture_unit.sv
module tb_iack_capture_unit;
    localparam int ACK_LEN = 2;
    localparam int GAP_LEN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq = 1'b0;
    logic       ack;
    logic [7:0] vec_bus = 8'h5A;
    logic [2:0] cas_bus = 3'd3;
    logic       sync, probe;
    logic       rd = 1'b0, wr = 1'b0, wdat = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] rdata;

    int checks = 0, fails = 0;
    int total_acks = 0, done_cnt = 0;
    logic [7:0] cur_vec = 8'h00;
    logic [2:0] cur_cas = 3'd0;
    logic [10:0] exp_q[$];
    logic [10:0] last_exp = '0;

    always #2.5 clk = ~clk;

    iack_capture_unit #(.ACK_LEN(ACK_LEN), .GAP_LEN(GAP_LEN)) dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ack_o(ack),
        .ctl_vec_i(vec_bus), .ctl_cas_i(cas_bus), .sync_o(sync), .probe_o(probe),
        .host_rd_i(rd), .host_wr_i(wr), .host_addr_i(addr),
        .host_wdata_i(wdat), .host_rdata_o(rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // responder: decoys outside the second pulse (R3)
    logic ack_prev = 1'b0;
    int   phase = 0;
    always @(negedge clk) begin
        if (ack && !ack_prev) phase = phase + 1;
        ack_prev = ack;
        if (ack && phase % 2 == 0) begin
            vec_bus = cur_vec; cas_bus = cur_cas;
        end else if (ack) begin
            vec_bus = 8'hEE; cas_bus = 3'd6;
        end else begin
            vec_bus = 8'h5A; cas_bus = 3'd3;
        end
    end

    // monitor: pulse shape and scoreboard pop
    int run = 0, gap = 0, slen = 0, seq_acks = 0;
    always @(negedge clk) begin
        if (ack) run++;
        else if (run > 0) begin
            check("R2 ack length", run, ACK_LEN);
            run = 0; total_acks++; seq_acks++;
        end
        if (sync) slen++;
        if (sync && !ack && seq_acks == 1) gap++;
        if (probe) begin
            check("R11 sync span", slen, 2*ACK_LEN + GAP_LEN);
            check("R11 sync low at probe", sync, 0);
            check("R2 gap length", gap, GAP_LEN);
            check("R2 two acks", seq_acks, 2);
            if (exp_q.size() == 0) check("R2 unexpected capture", 1, 0);
            else last_exp = exp_q.pop_front();
            slen = 0; gap = 0; seq_acks = 0; done_cnt++;
        end
    end

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] a, input logic v);
        @(negedge clk); wr = 1'b1; addr = a; wdat = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic expect_item(input logic [7:0] v, input logic [2:0] c);
        cur_vec = v; cur_cas = c; exp_q.push_back({v, c});
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 200 && done_cnt < target; i++) @(negedge clk);
        check("R2 sequence completed", done_cnt, target);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int acks0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack", ack, 0); check("R1 sync", sync, 0); check("R1 probe", probe, 0);
        host_read(2'd3, d); check("R1 status", d, 8'h02);

        // normal capture
        expect_item(8'h37, 3'd5);
        @(negedge clk); irq = 1'b1;
        wait_done(1);
        host_read(2'd3, d); check("R4 status avail", d, 8'h03);
        host_read(2'd1, d); check("R7 peek vector / R3 sample", d, last_exp[10:3]);
        host_read(2'd3, d); check("R7 flag kept", d, 8'h03);
        host_read(2'd2, d); check("R8 cascade", d, {5'd0, last_exp[2:0]});
        check("R2 level held no retrigger", total_acks, 2);

        // lock-out and no queueing
        irq = 1'b0; repeat (2) @(negedge clk);
        acks0 = total_acks;
        irq = 1'b1; repeat (20) @(negedge clk);
        check("R5 locked out", total_acks, acks0);
        host_read(2'd0, d); check("R6 clear read vector", d, 8'h37);
        host_read(2'd3, d); check("R6 flag cleared", d, 8'h02);
        repeat (20) @(negedge clk);
        check("R5 not queued", total_acks, acks0);
        irq = 1'b0; repeat (2) @(negedge clk);

        // disable
        host_write(2'd3, 1'b0);
        host_read(2'd3, d); check("R9 enable cleared", d, 8'h00);
        irq = 1'b1; repeat (20) @(negedge clk);
        check("R9 disabled no ack", total_acks, acks0);
        irq = 1'b0;

        // force while disabled
        expect_item(8'hA4, 3'd2);
        host_write(2'd0, 1'b0);
        wait_done(2);
        host_read(2'd1, d); check("R10 forced vector", d, 8'hA4);
        host_read(2'd2, d); check("R10 forced cascade", d, 8'h02);

        // force while flag held, with a second force during the run
        expect_item(8'h11, 3'd7);
        acks0 = total_acks;
        host_write(2'd0, 1'b0);
        host_write(2'd0, 1'b0);
        wait_done(3);
        repeat (20) @(negedge clk);
        check("R10 force during run ignored", total_acks, acks0 + 2);
        check("R10 single capture", done_cnt, 3);
        host_read(2'd0, d); check("R10 overwrite vector", d, 8'h11);

        // re-enable and capture again
        host_write(2'd3, 1'b1);
        host_read(2'd3, d); check("R9 enable set", d, 8'h02);
        expect_item(8'hFF, 3'd0);
        @(negedge clk); irq = 1'b1;
        wait_done(4);
        host_read(2'd0, d); check("R3 vector", d, 8'hFF);
        host_read(2'd2, d); check("R8 cascade zero", d, 8'h00);
        irq = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule